// File: doc/BRIEF.md
# Audio Serial Port Master Clock Generator

This block produces the bit clock and the left/right frame clock that an audio serial port drives when it is the clock master. Both clocks come from a single master clock. A 3-bit rate code selects how many master-clock cycles make up one frame: 256, 384, 512 or 768. A framing input selects one of two framings. Standard framing uses a square frame clock and a bit clock at one quarter of the master clock. DSP framing uses a one-bit-wide frame pulse and a bit clock running at the master-clock rate. Any rate code outside the supported four stops both clocks and raises an error flag.

All logic runs synchronously in the master-clock domain. The rate and framing inputs are captured on every rising edge. A captured change is applied only at the next frame boundary, so the port never sees a truncated frame. In standard framing the bit clock and the frame clock are register outputs. In DSP framing the bit clock is the master clock passed through a gate. That gate's enable changes only while the master clock is low.

Top module: `audio_master_clkgen`

## Requirements
- R1: While `rst_ni` is low, `bclk_o`, `lrclk_o` and `rate_err_o` are all 0. After release, the first rising edge only captures the inputs. The first frame begins on the second rising edge.
- R2: Rate code 3'b010 gives a frame of 256 master-clock cycles, 3'b011 gives 384, 3'b100 gives 512 and 3'b101 gives 768. The frame length is the distance between successive rising edges of `lrclk_o`.
- R3: In standard framing (`dsp_mode_i`=0), `bclk_o` repeats a pattern of 2 cycles low then 2 cycles high. Each frame starts at the beginning of a low phase.
- R4: In standard framing, `lrclk_o` is 0 (left) for the first half of each frame and 1 (right) for the second half.
- R5: In standard framing, every edge of `lrclk_o` occurs on the same master-clock edge as a falling edge of `bclk_o`.
- R6: In DSP framing (`dsp_mode_i`=1), `bclk_o` is high while the master clock is high and low while it is low.
- R7: In DSP framing, `lrclk_o` is high for exactly the first master-clock cycle of each frame.
- R8: Rate codes 3'b000, 3'b001, 3'b110 and 3'b111 hold `bclk_o` and `lrclk_o` at 0 and set `rate_err_o` to 1. With a supported code, `rate_err_o` is 0.
- R9: A new rate code or framing value takes effect at the first frame boundary after it has been captured; a running frame always finishes at its full length. While stopped on an invalid code, a newly captured valid code starts a frame on the next edge.
- R10: Asserting `rst_ni` at any point forces all outputs to 0 at once. The next frame after release starts with the left half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_sel_i | input | 3 | Frame-length code |
| dsp_mode_i | input | 1 | 1 selects DSP framing, 0 selects standard framing |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock or frame pulse |
| rate_err_o | output | 1 | Set while the applied rate code is unsupported |

## Verification
The hardest situation to reach is a configuration change that arrives in the middle of a frame. The block must hold the old length and framing until the exact boundary cycle and then switch cleanly, including switching into and out of DSP framing and into and out of the stopped state. The stimulus starts a frame and changes the code or the framing some cycles into it. A cycle-accurate reference model, built from the requirements, tracks the boundary and compares every cycle. In DSP framing the bit clock is also sampled during the low half of each master-clock period, to show that the gate never passes a stray high.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int unsigned RATE_W = 3;
  localparam int unsigned CNT_W  = 10;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [RATE_W-1:0] rate_t;

  // frame length in master-clock cycles; 0 marks an unsupported code
  function automatic cnt_t frame_len(input rate_t code);
    case (code)
      3'b010:  return cnt_t'(256);
      3'b011:  return cnt_t'(384);
      3'b100:  return cnt_t'(512);
      3'b101:  return cnt_t'(768);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/clkgen_frame_seq.sv
module clkgen_frame_seq
  import clkgen_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  rate_t rate_sel_i,
  input  logic  dsp_mode_i,
  output cnt_t  cnt_n_o,
  output cnt_t  len_n_o,
  output logic  dsp_n_o,
  output logic  run_n_o,
  output logic  eval_o
);
  rate_t rate_q;
  logic  dsp_in_q, in_vld_q;
  cnt_t  cnt_q, len_q;
  logic  dsp_q, run_q;
  logic  boundary;

  assign boundary = in_vld_q && (!run_q || cnt_q == len_q - cnt_t'(1));

  always_comb begin
    cnt_n_o = cnt_q + cnt_t'(1);
    len_n_o = len_q;
    dsp_n_o = dsp_q;
    run_n_o = run_q;
    if (boundary) begin
      len_n_o = frame_len(rate_q);
      dsp_n_o = dsp_in_q;
      run_n_o = (len_n_o != '0);
      cnt_n_o = '0;
    end else if (!run_q) begin
      cnt_n_o = '0;
    end
  end

  assign eval_o = in_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q   <= '0;
      dsp_in_q <= 1'b0;
      in_vld_q <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
      dsp_q    <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      rate_q   <= rate_sel_i;
      dsp_in_q <= dsp_mode_i;
      in_vld_q <= 1'b1;
      cnt_q    <= cnt_n_o;
      len_q    <= len_n_o;
      dsp_q    <= dsp_n_o;
      run_q    <= run_n_o;
    end
  end
endmodule

// File: rtl/clkgen_out_enc.sv
module clkgen_out_enc
  import clkgen_pkg::*;
#(
  parameter int unsigned BCLK_DIV_LOG2 = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  cnt_t cnt_n_i,
  input  cnt_t len_n_i,
  input  logic dsp_n_i,
  input  logic run_n_i,
  input  logic eval_i,
  output logic bclk_div_o,
  output logic lrclk_o,
  output logic err_o,
  output logic dsp_act_o,
  output logic gate_en_o
);
  logic bclk_n, lr_n, dsp_run_n;

  assign dsp_run_n = run_n_i & dsp_n_i;
  assign bclk_n    = run_n_i & ~dsp_n_i & cnt_n_i[BCLK_DIV_LOG2-1];
  assign lr_n      = run_n_i & (dsp_n_i ? (cnt_n_i == '0)
                                        : (cnt_n_i >= (len_n_i >> 1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_div_o <= 1'b0;
      lrclk_o    <= 1'b0;
      err_o      <= 1'b0;
      dsp_act_o  <= 1'b0;
    end else begin
      bclk_div_o <= bclk_n;
      lrclk_o    <= lr_n;
      err_o      <= eval_i & ~run_n_i;
      dsp_act_o  <= dsp_run_n;
    end
  end

  // enable for the pass-through gate moves only while the clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_en_o <= 1'b0;
    else         gate_en_o <= dsp_run_n;
  end
endmodule

// File: rtl/audio_master_clkgen.sv
module audio_master_clkgen
  import clkgen_pkg::*;
#(
  parameter int unsigned BCLK_DIV_LOG2 = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              dsp_mode_i,
  output logic              bclk_o,
  output logic              lrclk_o,
  output logic              rate_err_o
);
  cnt_t cnt_n, len_n;
  logic dsp_n, run_n, eval;
  logic bclk_div, dsp_act, gate_en;

  clkgen_frame_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rate_sel_i (rate_sel_i),
    .dsp_mode_i (dsp_mode_i),
    .cnt_n_o    (cnt_n),
    .len_n_o    (len_n),
    .dsp_n_o    (dsp_n),
    .run_n_o    (run_n),
    .eval_o     (eval)
  );

  clkgen_out_enc #(.BCLK_DIV_LOG2(BCLK_DIV_LOG2)) u_enc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_n_i    (cnt_n),
    .len_n_i    (len_n),
    .dsp_n_i    (dsp_n),
    .run_n_i    (run_n),
    .eval_i     (eval),
    .bclk_div_o (bclk_div),
    .lrclk_o    (lrclk_o),
    .err_o      (rate_err_o),
    .dsp_act_o  (dsp_act),
    .gate_en_o  (gate_en)
  );

  // DSP framing: bit clock is the master clock behind a low-phase gate
  assign bclk_o = bclk_div | (clk_i & gate_en);
endmodule

// File: rtl/audio_master_clkgen_chk.sv
module audio_master_clkgen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic lrclk_o,
  input logic rate_err_o,
  input logic bclk_div_i,
  input logic dsp_act_i
);
  a_r8_invalid_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_err_o |-> (!lrclk_o && !bclk_div_i && !dsp_act_i));

  a_r5_lr_on_bclk_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dsp_act_i && !$past(dsp_act_i) && (lrclk_o != $past(lrclk_o)))
      |-> $fell(bclk_div_i));

  a_r3_bclk_high_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bclk_div_i) |=> bclk_div_i);

  a_r7_dsp_pulse_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsp_act_i && lrclk_o) |=> !lrclk_o);

  a_r6_dsp_no_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsp_act_i |-> !bclk_div_i);
endmodule

bind audio_master_clkgen audio_master_clkgen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lrclk_o    (lrclk_o),
  .rate_err_o (rate_err_o),
  .bclk_div_i (bclk_div),
  .dsp_act_i  (dsp_act)
);

// File: tb/tb_audio_master_clkgen.sv
`timescale 1ns/1ps
module tb_audio_master_clkgen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] rate_sel_i = 3'b010;
  logic       dsp_mode_i = 1'b0;
  logic       bclk_o, lrclk_o, rate_err_o;

  int n_chk = 0, n_fail = 0;
  int m_vld, m_run, m_cnt, m_len, m_dsp, m_code_q, m_dsp_q, m_eval;
  int sp_last, mism;

  // code(3) dsp(1) expected frame length(10)
  localparam logic [13:0] VECS [8] = '{
    {3'b010, 1'b0, 10'd256}, {3'b011, 1'b0, 10'd384},
    {3'b100, 1'b0, 10'd512}, {3'b101, 1'b0, 10'd768},
    {3'b010, 1'b1, 10'd256}, {3'b101, 1'b1, 10'd768},
    {3'b000, 1'b0, 10'd0},   {3'b111, 1'b1, 10'd0}
  };

  always #4 clk_i = ~clk_i;

  audio_master_clkgen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rate_sel_i(rate_sel_i),
    .dsp_mode_i(dsp_mode_i), .bclk_o(bclk_o), .lrclk_o(lrclk_o),
    .rate_err_o(rate_err_o)
  );

  function automatic int len_of(input int code);
    case (code)
      2: return 256; 3: return 384; 4: return 512; 5: return 768;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mdl_clear();
    m_vld = 0; m_run = 0; m_cnt = 0; m_len = 0; m_dsp = 0;
    m_code_q = 0; m_dsp_q = 0; m_eval = 0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    mdl_clear();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // advance n cycles with the reference model, count mismatches
  task automatic run(input int n);
    int last_rise, prev_lr, e_b, e_l, e_e, e_bn;
    last_rise = -1; prev_lr = 0; sp_last = 0; mism = 0;
    for (int c = 0; c < n; c++) begin
      @(posedge clk_i);
      if (!m_vld) m_vld = 1;
      else if (!m_run || m_cnt == m_len - 1) begin
        m_len = len_of(m_code_q); m_dsp = m_dsp_q;
        m_run = (m_len != 0); m_cnt = 0; m_eval = 1;
      end else m_cnt++;
      m_code_q = int'(rate_sel_i); m_dsp_q = int'(dsp_mode_i);
      e_l = !m_run ? 0 : (m_dsp ? int'(m_cnt == 0) : int'(m_cnt >= m_len / 2));
      e_b = !m_run ? 0 : (m_dsp ? 1 : (m_cnt >> 1) & 1);
      e_bn = (m_run && !m_dsp) ? e_b : 0;
      e_e = m_eval && !m_run;
      #2;
      if (int'(bclk_o) != e_b || int'(lrclk_o) != e_l || int'(rate_err_o) != e_e) mism++;
      if (lrclk_o && !prev_lr) begin
        if (last_rise >= 0) sp_last = c - last_rise;
        last_rise = c;
      end
      prev_lr = int'(lrclk_o);
      @(negedge clk_i); #2;
      if (int'(bclk_o) != e_bn) mism++;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state with clock running
    repeat (2) @(posedge clk_i);
    #2;
    chk(!bclk_o && !lrclk_o && !rate_err_o, "R1 reset outputs",
        int'({bclk_o, lrclk_o, rate_err_o}), 0);

    for (int v = 0; v < 8; v++) begin
      int exp_len;
      rate_sel_i = VECS[v][13:11];
      dsp_mode_i = VECS[v][10];
      exp_len = int'(VECS[v][9:0]);
      do_reset();
      run(exp_len == 0 ? 20 : 2 * exp_len + 8);
      chk(mism == 0, dsp_mode_i ? "R6 R7 dsp waveform" : "R3 R4 standard waveform", mism, 0);
      chk(sp_last == exp_len, "R2 frame length", sp_last, exp_len);
      chk(int'(rate_err_o) == int'(exp_len == 0), "R8 error flag", int'(rate_err_o), int'(exp_len == 0));
    end

    // R9: rate change mid-frame keeps the running frame whole
    rate_sel_i = 3'b010; dsp_mode_i = 1'b0;
    do_reset();
    run(100);
    rate_sel_i = 3'b100;
    run(1300);
    chk(mism == 0, "R9 rate change at boundary", mism, 0);
    chk(sp_last == 512, "R9 new length applied", sp_last, 512);

    // R9: standard to DSP and back, mid-frame
    run(50);
    dsp_mode_i = 1'b1;
    run(700);
    chk(mism == 0, "R9 R6 switch into dsp", mism, 0);
    dsp_mode_i = 1'b0;
    run(1100);
    chk(mism == 0, "R9 R5 switch back to standard", mism, 0);

    // R8 R9: valid to invalid mid-frame, then recovery
    rate_sel_i = 3'b110;
    run(600);
    chk(mism == 0, "R8 R9 stop at boundary", mism, 0);
    chk(rate_err_o == 1'b1, "R8 flag after stop", int'(rate_err_o), 1);
    rate_sel_i = 3'b011;
    run(800);
    chk(mism == 0, "R9 restart from stopped", mism, 0);
    chk(sp_last == 384, "R9 R2 restarted length", sp_last, 384);

    // R10: asynchronous reset mid-frame while the master clock is high
    dsp_mode_i = 1'b1;
    run(1000);
    @(posedge clk_i); #1;
    rst_ni = 1'b0;
    #1;
    chk(!bclk_o && !lrclk_o && !rate_err_o, "R10 immediate clear",
        int'({bclk_o, lrclk_o, rate_err_o}), 0);
    mdl_clear();
    dsp_mode_i = 1'b0; rate_sel_i = 3'b010;
    @(negedge clk_i);
    rst_ni = 1'b1;
    run(300);
    chk(mism == 0, "R10 left half first after reset", mism, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule